// File: doc/BRIEF.md
# Byte-Stuffed Frame Receiver with Running CRC-8

This block sits behind a byte-wide host link (USB bridge or parallel port) and turns an escaped byte stream into framed payload. Frames are delimited by two-byte control sequences built from an escape byte, 0xA5. The value that follows the escape selects the meaning: 0x02 opens a frame, 0x03 closes it, and a second 0xA5 stands for one literal 0xA5 payload byte. The block removes the escapes and delivers each payload byte on a registered output stream. The first byte of a frame carries a flag, and the close of a frame raises a one-cycle pulse that carries no data.

A running CRC-8 covers every payload byte delivered. The generator is x^8+x^2+x+1, the register starts at zero, bits are taken most-significant first, and there is no reflection and no final inversion. The CRC runs on across frame boundaries. It returns to zero only on reset or on a pulse of the clear input. The host compares this value with its own checksum over everything it sent. Malformed escapes are dropped and latched in a sticky error flag. The only flow control is a ready signal on the output side.

Top module: `frame_unstuff_rx`

## Requirements
- R1: While and after a synchronous reset, out_valid, out_first, frame_end and proto_err are 0, crc_value is 0x00 and in_ready is 1.
- R2: After the sequence 0xA5 0x02, each non-escape input byte is delivered unchanged on out_data. It appears with out_valid high in the cycle after it is accepted, and the stream order is kept.
- R3: Inside a frame, the pair 0xA5 0xA5 is delivered as one payload byte of value 0xA5.
- R4: The pair 0xA5 0x03 inside a frame closes it and drives frame_end high for exactly one cycle, with no payload byte delivered for the pair.
- R5: out_first is 1 on the first payload byte delivered after each 0xA5 0x02 and 0 on all other payload bytes.
- R6: Outside a frame every byte is discarded, including the pairs 0xA5 0xA5 and 0xA5 0x03. No payload is delivered, frame_end stays low and the CRC does not change.
- R7: An 0xA5 followed by any value other than 0x02, 0x03 or 0xA5 is discarded together with that value. It sets proto_err, which stays 1 until reset.
- R8: A 0xA5 0x02 arriving inside an open frame abandons that frame without a frame_end pulse and starts a new one. The next payload byte carries out_first.
- R9: crc_value is the CRC-8 with polynomial 0x107 (feedback 0x07), initial value 0x00, MSB first, no reflection and no final XOR, over all payload bytes delivered since the last reset or clear. It carries across frames and never includes control sequences.
- R10: A cycle with crc_clear high makes crc_value 0x00 on the next cycle. This holds even when a payload byte is accepted in the same cycle; that byte is still delivered but is left out of the CRC.
- R11: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_data and out_first hold their values.
- R12: With out_ready held high, one input byte is accepted on every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_clear | input | 1 | Returns the running CRC to zero |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte from the host link |
| in_ready | output | 1 | Input byte is taken at this edge when in_valid is high |
| out_valid | output | 1 | Payload byte present on out_data |
| out_data | output | 8 | Unescaped payload byte |
| out_first | output | 1 | First payload byte of a frame |
| out_ready | input | 1 | Downstream accepts the payload byte |
| frame_end | output | 1 | One-cycle pulse at the close of a frame |
| proto_err | output | 1 | Sticky flag for an invalid escape code |
| crc_value | output | 8 | Running CRC-8 over delivered payload |

## Verification
The bench goes after escaped 0xA5 payload. A design that forwarded both bytes would put a spurious byte in the stream and corrupt the CRC. It sends escapes and stray bytes outside any frame, which a careless parser would leak as payload or answer with a frame_end pulse. It also sends a restart inside an open frame, where a wrong design would miss the first flag or emit a false end pulse. Bad escape codes check that the error flag is latched and that both bytes are dropped. A clear that lands on a payload byte checks that the clear takes priority. Random frames with random downstream stalls check that out_data is held while stalled, that input stops exactly when it should, and that the CRC carries across many frames in agreement with a bitwise reference.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;
  localparam int unsigned FR_BYTE_W = 8;
  typedef logic [FR_BYTE_W-1:0] fr_byte_t;

  // One decoded input step
  typedef struct packed {
    logic     emit;   // payload byte to deliver
    fr_byte_t data;
    logic     first;  // first payload byte of a frame
    logic     sof;    // start sequence seen
    logic     eof;    // end sequence closed an open frame
    logic     err;    // invalid code after escape
  } fr_dec_t;
endpackage

// File: rtl/fr_escape_decoder.sv
module fr_escape_decoder
  import frame_rx_pkg::*;
#(
  parameter fr_byte_t ESC_BYTE = 8'hA5,
  parameter fr_byte_t SOF_CODE = 8'h02,
  parameter fr_byte_t EOF_CODE = 8'h03
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  input  fr_byte_t byte_in,
  output fr_dec_t  dec
);
  logic esc_pend, in_frame, first_pend;

  always_comb begin
    dec = '0;
    dec.data = byte_in;
    if (step) begin
      if (esc_pend) begin
        if (byte_in == SOF_CODE) begin
          dec.sof = 1'b1;
        end else if (byte_in == EOF_CODE) begin
          dec.eof = in_frame;
        end else if (byte_in == ESC_BYTE) begin
          dec.emit  = in_frame;
          dec.first = first_pend;
        end else begin
          dec.err = 1'b1;
        end
      end else if (byte_in != ESC_BYTE) begin
        dec.emit  = in_frame;
        dec.first = first_pend;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      esc_pend   <= 1'b0;
      in_frame   <= 1'b0;
      first_pend <= 1'b0;
    end else if (step) begin
      esc_pend <= !esc_pend && (byte_in == ESC_BYTE);
      if (dec.sof) begin
        in_frame   <= 1'b1;
        first_pend <= 1'b1;
      end else begin
        if (dec.eof)  in_frame   <= 1'b0;
        if (dec.emit) first_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fr_crc_accum.sv
module fr_crc_accum
  import frame_rx_pkg::*;
#(
  parameter fr_byte_t POLY_LOW = 8'h07
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     clear,
  input  logic     update,
  input  fr_byte_t data,
  output fr_byte_t crc
);
  fr_byte_t nxt;

  always_comb begin
    nxt = crc;
    for (int i = FR_BYTE_W - 1; i >= 0; i--) begin
      if (nxt[FR_BYTE_W-1] ^ data[i]) nxt = {nxt[FR_BYTE_W-2:0], 1'b0} ^ POLY_LOW;
      else                            nxt = {nxt[FR_BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) crc <= '0;
    else if (update)  crc <= nxt;
  end
endmodule

// File: rtl/fr_out_stage.sv
module fr_out_stage
  import frame_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  fr_dec_t  dec,
  input  logic     out_ready,
  output logic     in_ready,
  output logic     out_valid,
  output fr_byte_t out_data,
  output logic     out_first,
  output logic     frame_end
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      frame_end <= dec.eof;
      if (dec.emit) begin
        out_valid <= 1'b1;
        out_first <= dec.first;
      end else if (out_ready) begin
        out_valid <= 1'b0;
        out_first <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dec.emit) out_data <= dec.data;
  end
endmodule

// File: rtl/frame_unstuff_rx.sv
module frame_unstuff_rx
  import frame_rx_pkg::*;
#(
  parameter fr_byte_t ESC_BYTE = 8'hA5,
  parameter fr_byte_t SOF_CODE = 8'h02,
  parameter fr_byte_t EOF_CODE = 8'h03,
  parameter fr_byte_t POLY_LOW = 8'h07
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       crc_clear,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_first,
  input  logic       out_ready,
  output logic       frame_end,
  output logic       proto_err,
  output logic [7:0] crc_value
);
  logic    accept;
  fr_dec_t dec;

  assign accept = in_valid && in_ready;

  fr_escape_decoder #(
    .ESC_BYTE(ESC_BYTE), .SOF_CODE(SOF_CODE), .EOF_CODE(EOF_CODE)
  ) u_dec (
    .clk(clk), .rst(rst), .step(accept), .byte_in(in_data), .dec(dec)
  );

  fr_crc_accum #(.POLY_LOW(POLY_LOW)) u_crc (
    .clk(clk), .rst(rst), .clear(crc_clear), .update(dec.emit),
    .data(dec.data), .crc(crc_value)
  );

  fr_out_stage u_out (
    .clk(clk), .rst(rst), .dec(dec), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .frame_end(frame_end)
  );

  always_ff @(posedge clk) begin
    if (rst)          proto_err <= 1'b0;
    else if (dec.err) proto_err <= 1'b1;
  end
endmodule

// File: rtl/frame_unstuff_rx_chk.sv
module frame_unstuff_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       crc_clear,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_first,
  input logic       out_ready,
  input logic       frame_end,
  input logic       proto_err,
  input logic [7:0] crc_value
);
  // R4
  frame_end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  // R10
  crc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    crc_clear |=> (crc_value == 8'h00));

  // R9
  crc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready) && !crc_clear) |=> $stable(crc_value));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_first)));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind frame_unstuff_rx frame_unstuff_rx_chk u_chk (
  .clk(clk), .rst(rst), .crc_clear(crc_clear), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .out_first(out_first), .out_ready(out_ready), .frame_end(frame_end),
  .proto_err(proto_err), .crc_value(crc_value)
);

// File: tb/frame_unstuff_rx_tb.sv
module frame_unstuff_rx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       crc_clear = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_first;
  logic       out_ready = 1'b1;
  logic       frame_end;
  logic       proto_err;
  logic [7:0] crc_value;

  always #10 clk = ~clk;

  frame_unstuff_rx u_dut (
    .clk(clk), .rst(rst), .crc_clear(crc_clear), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_first(out_first), .out_ready(out_ready),
    .frame_end(frame_end), .proto_err(proto_err), .crc_value(crc_value)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [8:0] expq[$];
  bit m_esc = 0, m_inf = 0, m_first = 0, m_err = 0;
  logic [7:0] m_crc = 8'h00;
  int exp_eof = 0, seen_eof = 0;
  int rdy_mode = 1;   // 0 low, 1 high, 2 random

  function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ b[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_payload(input logic [7:0] b, input bit clr);
    expq.push_back({m_first, b});
    m_first = 0;
    if (!clr) m_crc = crc_ref(m_crc, b);
  endtask

  task automatic model_accept(input logic [7:0] b, input bit clr);
    if (m_esc) begin
      m_esc = 0;
      if (b == 8'h02) begin m_inf = 1; m_first = 1; end
      else if (b == 8'h03) begin if (m_inf) begin exp_eof++; m_inf = 0; end end
      else if (b == 8'hA5) begin if (m_inf) push_payload(b, clr); end
      else m_err = 1;
    end else if (b == 8'hA5) begin
      m_esc = 1;
    end else if (m_inf) begin
      push_payload(b, clr);
    end
  endtask

  task automatic cycle(input bit v, input logic [7:0] b, input bit clr, output bit acc);
    logic [8:0] e;
    @(negedge clk);
    in_valid  = v;
    in_data   = b;
    crc_clear = clr;
    out_ready = (rdy_mode == 2) ? 1'($urandom_range(0, 1)) : (rdy_mode == 1);
    #1;
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(0, "R6", "unexpected payload byte", out_data, 0);
      end else begin
        e = expq.pop_front();
        check(out_data == e[7:0], "R2/R3", "payload byte", out_data, e[7:0]);
        check(out_first == e[8], "R5", "first flag", out_first, e[8]);
      end
    end
    if (frame_end) seen_eof++;
    acc = v && in_ready;
    if (clr) m_crc = 8'h00;
    if (acc) model_accept(b, clr);
  endtask

  task automatic send(input logic [7:0] b);
    bit acc;
    do cycle(1'b1, b, 1'b0, acc); while (!acc);
  endtask

  task automatic send_payload(input logic [7:0] b);
    if (b == 8'hA5) send(8'hA5);
    send(b);
  endtask

  task automatic drain();
    bit acc;
    int keep;
    keep = rdy_mode;
    rdy_mode = 1;
    repeat (4) cycle(1'b0, 8'h00, 1'b0, acc);
    rdy_mode = keep;
  endtask

  task automatic sync(input string req);
    drain();
    check(expq.size() == 0, req, "bytes still pending", expq.size(), 0);
    check(seen_eof == exp_eof, "R4", "frame_end count", seen_eof, exp_eof);
    check(crc_value == m_crc, "R9", "crc value", crc_value, m_crc);
    check(proto_err == m_err, "R7", "error flag", proto_err, m_err);
  endtask

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit acc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(!out_valid && !out_first, "R1", "out_valid/first in reset", out_valid, 0);
    check(!frame_end && !proto_err, "R1", "flags in reset", {frame_end, proto_err}, 0);
    check(crc_value == 8'h00 && in_ready, "R1", "crc/ready in reset", crc_value, 0);
    rst = 1'b0;

    // R2 R4 R9 plain frame
    send(8'hA5); send(8'h02); send(8'h11); send(8'h22); send(8'h33);
    send(8'hA5); send(8'h03);
    sync("R2");

    // R3 escaped payload
    send(8'hA5); send(8'h02); send(8'hA5); send(8'hA5); send(8'h44);
    send(8'hA5); send(8'h03);
    sync("R3");

    // R6 bytes outside a frame
    send(8'h55); send(8'hA5); send(8'hA5); send(8'hA5); send(8'h03); send(8'h66);
    sync("R6");

    // R8 restart inside an open frame
    send(8'hA5); send(8'h02); send(8'h01); send(8'h02);
    send(8'hA5); send(8'h02); send(8'h03); send(8'hA5); send(8'h03);
    sync("R8");

    // R7 bad escape code
    send(8'hA5); send(8'h02); send(8'h07); send(8'hA5); send(8'h10); send(8'h08);
    send(8'hA5); send(8'h03);
    sync("R7");
    check(proto_err == 1'b1, "R7", "sticky error set", proto_err, 1);

    // R10 clear alone, then clear on a payload byte
    cycle(1'b0, 8'h00, 1'b1, acc);
    cycle(1'b0, 8'h00, 1'b0, acc);
    check(crc_value == 8'h00, "R10", "crc after clear", crc_value, 0);
    send(8'hA5); send(8'h02);
    cycle(1'b1, 8'h5A, 1'b1, acc);
    check(acc, "R10", "byte accepted with clear", acc, 1);
    send(8'h5B); send(8'hA5); send(8'h03);
    sync("R10");

    // R12 back-to-back acceptance
    begin
      int missed = 0;
      logic [7:0] seq[12] = '{8'hA5, 8'h02, 8'h10, 8'h20, 8'h30, 8'h40,
                               8'h50, 8'h60, 8'h70, 8'h80, 8'hA5, 8'h03};
      foreach (seq[i]) begin
        cycle(1'b1, seq[i], 1'b0, acc);
        if (!acc) missed++;
      end
      check(missed == 0, "R12", "stalled cycles at full rate", missed, 0);
      sync("R12");
    end

    // R11 stall holds output and blocks input
    send(8'hA5); send(8'h02); send(8'h77);
    rdy_mode = 0;
    repeat (3) begin
      cycle(1'b1, 8'h88, 1'b0, acc);
      check(!acc && !in_ready, "R11", "in_ready while stalled", in_ready, 0);
      check(out_valid && out_data == 8'h77, "R11", "held data", out_data, 8'h77);
    end
    rdy_mode = 1;
    send(8'h88); send(8'hA5); send(8'h03);
    sync("R11");

    // Random frames under random backpressure
    rdy_mode = 2;
    for (int f = 0; f < 60; f++) begin
      int len;
      if ($urandom_range(0, 3) == 0) send(8'($urandom_range(0, 255)));
      if ($urandom_range(0, 9) == 0) begin
        cycle(1'b0, 8'h00, 1'b1, acc);
      end
      send(8'hA5); send(8'h02);
      len = $urandom_range(0, 12);
      for (int k = 0; k < len; k++) begin
        if ($urandom_range(0, 3) == 0) send_payload(8'hA5);
        else send_payload(8'($urandom_range(0, 255)));
        if ($urandom_range(0, 15) == 0) begin send(8'hA5); send(8'h09); end
      end
      send(8'hA5); send(8'h03);
      if (f % 6 == 5) sync("R9");
    end
    sync("R9");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule